// File: doc/BRIEF.md
# Bus Wait-State Watchdog Timer

This block guards the host bus against a peripheral that holds the wait line forever. It measures how long the wait signal has been asserted without a break, counted in master clock cycles. When that time reaches a parameterized limit, the block raises a sticky timeout flag and an interrupt request. It also sends a one-cycle set strobe to each of the two configuration registers that carry an interrupt status bit: the function option register and the card configuration register.

The watchdog is armed by one enable bit, bit 6 of the watchdog control byte. The block receives that byte whole and ignores its other bits. Address decoding, the registers that hold the interrupt bits and the interrupt pin driver all sit outside the block.

The wait line comes from the host side and passes through a synchronizer before the counter sees it. The reset is asserted asynchronously and released in step with the clock. The default limit is about eleven milliseconds at a 20 MHz master clock. A bench can set a much shorter limit.

Top module: `bus_wait_watchdog`

## Requirements
- R1: While reset is held, and after it is released with no wait asserted, `tmo_flag_o`, `irq_req_o`, `opt_intr_set_o` and `card_intr_set_o` are all 0.
- R2: `host_wait_n_i` is asserted when low. With the watchdog enabled, an assertion lasting LIMIT consecutive clock cycles or longer sets `tmo_flag_o`. The flag rises SYNC_STAGES+LIMIT+1 rising edges after the first asserted cycle. An assertion of LIMIT-1 cycles never sets the flag.
- R3: On expiry, `opt_intr_set_o` and `card_intr_set_o` each pulse high for exactly one cycle, in the same cycle that `tmo_flag_o` rises. `irq_req_o` then goes high.
- R4: Any deassertion of the wait line restarts the count from zero. Two assertions that are each shorter than LIMIT never cause a timeout, whatever their combined length.
- R5: `tmo_flag_o` stays set until `tmo_clr_i` is high at a rising edge; flag and `irq_req_o` are then 0 from that edge on. If a clear and an expiry meet at the same edge, the expiry wins and the flag stays set.
- R6: One unbroken assertion produces exactly one set strobe per register, however long it lasts. Clearing the flag while that assertion goes on does not raise it again. A new assertion after a release can time out again.
- R7: When bit 6 of `wd_reg_i` is 0, the block produces no timeout and no interrupt, however long the wait lasts. Bits 7 and 5..0 have no effect. Clearing bit 6 during a wait restarts the count. `irq_req_o` is the flag gated by bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wait_n_i | input | 1 | Host wait line, low means asserted |
| wd_reg_i | input | 8 | Watchdog control byte; bit 6 enables the timer |
| tmo_clr_i | input | 1 | Software clear of the timeout flag |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| irq_req_o | output | 1 | Interrupt request, flag gated by the enable bit |
| opt_intr_set_o | output | 1 | One-cycle strobe that sets the interrupt bit in the function option register |
| card_intr_set_o | output | 1 | One-cycle strobe that sets the interrupt bit in the card configuration register |

## Verification
The wait line is driven in several shapes: one unbroken assertion sampled on the cycle just before and the cycle of the expected expiry, assertions of exactly LIMIT-1 and exactly LIMIT cycles, and two short bursts with a one-cycle gap. Together these separate an off-by-one in the limit, a counter that does not restart, and a latency error. A long assertion held well past expiry, with a clear in the middle, shows whether the block produces one event or several. The enable byte is varied separately: reserved bits are set while bit 6 is 0, the enable is dropped in the middle of a wait, and a clear is made to coincide with the expiry edge. These cases show whether the enable gating and the set-over-clear priority are correct.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  // width of the watchdog control byte and position of its enable bit
  parameter int unsigned BWD_REG_W  = 8;
  parameter int unsigned BWD_EN_BIT = 6;

  // event state shared between the event stage and the top
  typedef struct packed {
    logic flag;
    logic opt_set;
    logic card_set;
  } bwd_evt_t;
endpackage

// File: rtl/bwd_rst_sync.sv
module bwd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/bwd_sync.sv
module bwd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          ACT_LOW = 1'b1
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic wait_raw_i,
  output logic wait_act_o
);
  logic wait_lvl;
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (ACT_LOW) begin : g_low
      assign wait_lvl = ~wait_raw_i;
    end else begin : g_high
      assign wait_lvl = wait_raw_i;
    end
  endgenerate

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = wait_lvl;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], wait_lvl};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign wait_act_o = sync_q[STAGES-1];
endmodule

// File: rtl/bwd_count.sv
module bwd_count #(
  parameter int unsigned LIMIT = 224000,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic en_i,
  input  logic wait_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d = cnt_q;
    if (!(en_i && wait_i))     cnt_d = '0;
    else if (cnt_q != LIMIT_C) cnt_d = cnt_q + 1'b1;
    cnt_ce = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == LIMIT_C);

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(en_i && wait_i) |=> (cnt_q == '0)); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && wait_i && (cnt_q != LIMIT_C)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_CNT_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    expired_o && en_i && wait_i |=> expired_o); // R6
endmodule

// File: rtl/bwd_event.sv
module bwd_event
  import bwd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_n,
  input  logic     expired_i,
  input  logic     clr_i,
  output bwd_evt_t evt_o
);
  logic     exp_q;
  logic     rise;
  bwd_evt_t evt_q;
  bwd_evt_t evt_d;

  always_comb begin
    rise           = expired_i && !exp_q;
    evt_d.opt_set  = rise;
    evt_d.card_set = rise;
    if (rise)       evt_d.flag = 1'b1;
    else if (clr_i) evt_d.flag = 1'b0;
    else            evt_d.flag = evt_q.flag;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= 1'b0;
      evt_q <= '0;
    end else begin
      exp_q <= expired_i;
      evt_q <= evt_d;
    end
  end

  assign evt_o = evt_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_q.opt_set |=> !evt_q.opt_set); // R6
  AST_PULSE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_q.opt_set == evt_q.card_set); // R3
  AST_PULSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_q.opt_set |-> evt_q.flag); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (evt_q.flag && !clr_i) |=> evt_q.flag); // R5
endmodule

// File: rtl/bus_wait_watchdog.sv
module bus_wait_watchdog
  import bwd_pkg::*;
#(
  parameter int unsigned LIMIT        = 224000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter bit          WAIT_ACT_LOW = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 host_wait_n_i,
  input  logic [BWD_REG_W-1:0] wd_reg_i,
  input  logic                 tmo_clr_i,
  output logic                 tmo_flag_o,
  output logic                 irq_req_o,
  output logic                 opt_intr_set_o,
  output logic                 card_intr_set_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic     rst_n;
  logic     wait_s;
  logic     wd_en;
  logic     expired;
  bwd_evt_t evt;

  assign wd_en = wd_reg_i[BWD_EN_BIT];

  bwd_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n)
  );

  bwd_sync #(.STAGES(SYNC_STAGES), .ACT_LOW(WAIT_ACT_LOW)) u_sync (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .wait_raw_i (host_wait_n_i),
    .wait_act_o (wait_s)
  );

  bwd_count #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .en_i      (wd_en),
    .wait_i    (wait_s),
    .expired_o (expired)
  );

  bwd_event u_evt (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .expired_i (expired),
    .clr_i     (tmo_clr_i),
    .evt_o     (evt)
  );

  assign tmo_flag_o      = evt.flag;
  assign irq_req_o       = evt.flag && wd_en;
  assign opt_intr_set_o  = evt.opt_set;
  assign card_intr_set_o = evt.card_set;

  AST_RISE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(tmo_flag_o) |-> $past(wd_en)); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tmo_clr_i && !expired) |=> !tmo_flag_o); // R5
endmodule

// File: tb/bus_wait_watchdog_tb.sv
module bus_wait_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 20;
  localparam int SYN        = 2;
  localparam int LAT        = SYN + LIM + 1; // edges from first asserted cycle to flag

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wait_n;
  logic [7:0] wreg;
  logic       clr;
  logic       flag, irq, opt_set, card_set;

  int total = 0;
  int bad   = 0;
  int n_opt = 0;
  int n_card = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wait_watchdog #(.LIMIT(LIM), .SYNC_STAGES(SYN), .WAIT_ACT_LOW(1'b1)) u_dut (
    .clk_i           (clk),
    .rst_n_i         (rst_n),
    .host_wait_n_i   (wait_n),
    .wd_reg_i        (wreg),
    .tmo_clr_i       (clr),
    .tmo_flag_o      (flag),
    .irq_req_o       (irq),
    .opt_intr_set_o  (opt_set),
    .card_intr_set_o (card_set)
  );

  always @(negedge clk) begin
    if (rst_n && opt_set)  n_opt  <= n_opt + 1;
    if (rst_n && card_set) n_card <= n_card + 1;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cleanup();
    wait_n = 1'b1;
    wreg   = 8'h40;
    clr    = 1'b1;
    tick(1);
    clr = 1'b0;
    tick(4);
    n_opt  = 0;
    n_card = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wait_n = 1'b1; wreg = 8'h40; clr = 1'b0;
    tick(3);
    chk("R1 flag in reset", flag, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    tick(6);
    chk("R1 flag after reset", flag, 0);
    chk("R1 strobes after reset", opt_set | card_set, 0);
  endtask

  task automatic t_long_wait();
    wait_n = 1'b0;
    tick(LAT - 1);
    chk("R2 flag one edge early", flag, 0);
    tick(1);
    chk("R2 flag at expiry", flag, 1);
    chk("R3 option strobe", opt_set, 1);
    chk("R3 card strobe", card_set, 1);
    chk("R3 irq raised", irq, 1);
    tick(1);
    chk("R3 strobe one cycle", opt_set, 0);
    tick(60);
    chk("R6 one option event", n_opt, 1);
    chk("R6 one card event", n_card, 1);
    cleanup();
  endtask

  task automatic t_boundary();
    wait_n = 1'b0; tick(LIM - 1); wait_n = 1'b1; tick(10);
    chk("R2 LIMIT-1 no timeout", flag, 0);
    cleanup();
    wait_n = 1'b0; tick(LIM); wait_n = 1'b1; tick(10);
    chk("R2 LIMIT times out", flag, 1);
    cleanup();
  endtask

  task automatic t_restart();
    wait_n = 1'b0; tick(LIM - 2);
    wait_n = 1'b1; tick(1);
    wait_n = 1'b0; tick(LIM - 2);
    wait_n = 1'b1; tick(10);
    chk("R4 split wait no timeout", flag, 0);
    chk("R4 no strobes", n_opt, 0);
    cleanup();
  endtask

  task automatic t_clear();
    wait_n = 1'b0; tick(LIM + 2); wait_n = 1'b1; tick(30);
    chk("R5 flag sticky", flag, 1);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R5 flag cleared", flag, 0);
    chk("R5 irq cleared", irq, 0);
    cleanup();
    // clear on the very edge of expiry: expiry wins
    wait_n = 1'b0; tick(LAT - 1);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R5 set beats clear", flag, 1);
    cleanup();
  endtask

  task automatic t_clear_during_wait();
    wait_n = 1'b0; tick(LAT + 3);
    clr = 1'b1; tick(1); clr = 1'b0;
    tick(40);
    chk("R6 no re-raise in same wait", flag, 0);
    chk("R6 single strobe", n_opt, 1);
    wait_n = 1'b1; tick(3);
    wait_n = 1'b0; tick(LAT + 1);
    chk("R6 new wait raises again", flag, 1);
    chk("R6 second event", n_card, 2);
    cleanup();
  endtask

  task automatic t_enable();
    wreg = 8'hBF; // every bit but bit 6
    wait_n = 1'b0; tick(3 * LIM);
    chk("R7 disabled no flag", flag, 0);
    chk("R7 disabled no irq", irq, 0);
    chk("R7 disabled no strobe", n_opt, 0);
    cleanup();
    wait_n = 1'b0; tick(LIM - 4);
    wreg = 8'h00; tick(1);
    wreg = 8'h40; tick(LIM - 4);
    chk("R7 enable drop restarts", flag, 0);
    tick(20);
    chk("R7 re-enabled times out", flag, 1);
    wreg = 8'h00; tick(1);
    chk("R7 irq gated by enable", irq, 0);
    chk("R7 flag kept when disabled", flag, 1);
    cleanup();
  endtask

  initial begin
    t_reset();
    t_long_wait();
    t_boundary();
    t_restart();
    t_clear();
    t_clear_during_wait();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule